// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block drives the raster timing of a digital LCD panel from a single pixel clock. It produces five things. The first is a shift clock that runs at the pixel rate. The second is an active-low line pulse and the third an active-low frame pulse. The fourth is a data-ready strobe that is high while visible pixels are on the bus. The fifth is a pixel-request strobe that leads data-ready by one clock, so an upstream pixel source can present each pixel in time. Horizontal and vertical position counters are also brought out so that the source knows which pixel is being asked for.

The geometry comes from five fields. The active width and the blanking width are given in 8-pixel units, and blanking carries a built-in offset of four units. The line pulse position is set within the blanking interval. The active height and the blanking height are given in lines. The fields are latched while reset is held, and again at the last pixel of each frame, so a frame never mixes old and new settings. The line pulse is a fixed 9 clocks wide. It falls a programmable distance after data-ready drops. The frame pulse spans two full lines. It starts 18 clocks after the line pulse of the last line of a frame, which places it one line minus 18 clocks ahead of the next line pulse.

Top module: `lcd_timing_gen`

## Requirements
- R1: `sclk_o` is the pixel clock passed straight through, so it has a 50% duty cycle. Every other output changes only on the rising edge of the pixel clock. It is therefore stable for half a period before each falling edge of `sclk_o` and for half a period after it.
- R2: A line lasts HT = (act_w+1)·8 + (blank_w+4)·8 clocks. `hpos_o` counts 0 to HT−1, then returns to 0.
- R3: A frame lasts VT = (act_h+1) + blank_h lines. `vpos_o` holds its value during a line, increments when `hpos_o` wraps, and returns to 0 after line VT−1.
- R4: `pix_req_o` is high exactly when `hpos_o` < (act_w+1)·8 and `vpos_o` < act_h+1. `drdy_o` equals `pix_req_o` delayed by one clock, so each high run of `drdy_o` lasts (act_w+1)·8 clocks.
- R5: `drdy_o` stays low for the whole of every line with `vpos_o` ≥ act_h+1.
- R6: In every line, `lp_n_o` is low for exactly 9 consecutive clocks. Its falling edge comes lp_pos·8+16 clocks after the falling edge of `drdy_o`, that is, on the clock after `hpos_o` equals (act_w+1)·8 + lp_pos·8 + 16. This holds for any lp_pos ≤ blank_w.
- R7: `fp_n_o` falls exactly 18 clocks after the falling edge of `lp_n_o` in line VT−1. It stays low for exactly two line periods and rises 18 clocks after the second following falling edge of `lp_n_o`.
- R8: While `rst_i` is high at a rising clock edge, `hpos_o` and `vpos_o` clear to 0, `lp_n_o` and `fp_n_o` go high, and `drdy_o` goes low.
- R9: The geometry fields are sampled during reset and at the clock edge where `hpos_o` = HT−1 and `vpos_o` = VT−1. A change at any other time has no effect until the next frame begins.
- R10: `lp_n_o` is never low while `drdy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| act_w_i | input | HDP_W (7) | Active width in 8-pixel units, minus one |
| blank_w_i | input | HNDP_W (5) | Horizontal blanking in 8-pixel units, minus four |
| lp_pos_i | input | HPS_W (5) | Line pulse position in 8-pixel units; must not exceed blank_w_i |
| act_h_i | input | VDP_W (10) | Active height in lines, minus one |
| blank_h_i | input | VNDP_W (7) | Vertical blanking in lines |
| sclk_o | output | 1 | Shift clock to the panel |
| lp_n_o | output | 1 | Line pulse, active low |
| fp_n_o | output | 1 | Frame pulse, active low |
| drdy_o | output | 1 | Data-ready strobe, high during visible pixels |
| pix_req_o | output | 1 | Pixel request, one clock ahead of drdy_o |
| hpos_o | output | HCNT_W (11) | Horizontal pixel counter |
| vpos_o | output | VCNT_W (11) | Vertical line counter |

## Verification
The bench sets the line pulse position equal to the blanking width. This puts the 9-clock pulse as close as possible to the end of the line, where an off-by-one in the 16-clock offset or the pulse width would be visible. It runs a geometry with no vertical blanking lines, and a frame only four lines tall, where a frame pulse started in the wrong line or held for the wrong count would overlap the next frame's. It also changes every field in the middle of a frame. A design that applied the change at once would shift `hpos_o` wrap points and `drdy_o` widths before the frame boundary, where the reference still expects the old geometry.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

   // Width of the decoded geometry values carried between submodules.
   localparam int GEOM_W = 16;

   // Decoded geometry, all counts in pixel clocks or lines.
   typedef struct packed {
      logic [GEOM_W-1:0] h_total;   // clocks per line
      logic [GEOM_W-1:0] h_disp;    // visible clocks per line
      logic [GEOM_W-1:0] lp_start;  // hpos at which the line pulse falls
      logic [GEOM_W-1:0] v_total;   // lines per frame
      logic [GEOM_W-1:0] v_disp;    // visible lines per frame
   } lcdt_geom_t;

endpackage

// File: rtl/lcdt_shadow.sv
module lcdt_shadow
   import lcdt_pkg::*;
#(
   parameter bit SHADOW_EN = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       load_i,
   input  lcdt_geom_t geom_d_i,
   output lcdt_geom_t geom_q_o
);

   generate
      if (SHADOW_EN) begin : g_latched
         lcdt_geom_t geom_q;
         always_ff @(posedge clk_i) begin
            if (rst_i || load_i) begin
               geom_q <= geom_d_i;
            end
         end
         assign geom_q_o = geom_q;
      end else begin : g_live
         logic unused_ctl;
         assign unused_ctl = clk_i ^ rst_i ^ load_i;
         assign geom_q_o   = geom_d_i;
      end
   endgenerate

endmodule

// File: rtl/lcdt_raster_cnt.sv
module lcdt_raster_cnt
   import lcdt_pkg::*;
#(
   parameter int HCNT_W = 11,
   parameter int VCNT_W = 11
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [GEOM_W-1:0] h_total_i,
   input  logic [GEOM_W-1:0] v_total_i,
   output logic [HCNT_W-1:0] h_o,
   output logic [VCNT_W-1:0] v_o,
   output logic              frame_end_o
);

   logic [HCNT_W-1:0] h_q;
   logic [VCNT_W-1:0] v_q;
   logic              line_end;
   logic              last_line;

   assign line_end    = (GEOM_W'(h_q) == h_total_i - GEOM_W'(1));
   assign last_line   = (GEOM_W'(v_q) == v_total_i - GEOM_W'(1));
   assign frame_end_o = line_end && last_line;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         h_q <= '0;
         v_q <= '0;
      end else if (line_end) begin
         h_q <= '0;
         if (last_line) begin
            v_q <= '0;
         end else begin
            v_q <= v_q + VCNT_W'(1);
         end
      end else begin
         h_q <= h_q + HCNT_W'(1);
      end
   end

   assign h_o = h_q;
   assign v_o = v_q;

endmodule

// File: rtl/lcdt_pulse_gen.sv
module lcdt_pulse_gen
   import lcdt_pkg::*;
#(
   parameter int HCNT_W   = 11,
   parameter int VCNT_W   = 11,
   parameter int LP_WIDTH = 9,
   parameter int FP_LEAD  = 18,
   parameter int FP_LINES = 2,
   localparam int DLY_W   = $clog2(FP_LEAD + 1),
   localparam int REM_W   = $clog2(FP_LINES + 1)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [HCNT_W-1:0] h_i,
   input  logic [VCNT_W-1:0] v_i,
   input  logic [GEOM_W-1:0] h_disp_i,
   input  logic [GEOM_W-1:0] lp_start_i,
   input  logic [GEOM_W-1:0] v_disp_i,
   input  logic [GEOM_W-1:0] v_total_i,
   output logic              pix_req_o,
   output logic              drdy_o,
   output logic              lp_n_o,
   output logic              fp_n_o
);

   logic [GEOM_W-1:0] hx;
   logic [GEOM_W-1:0] vx;
   logic              in_lp_win;
   logic              lp_fall_now;
   logic              last_line;

   logic              drdy_q;
   logic              lp_n_q;
   logic              fp_n_q;
   logic              dly_run_q;
   logic [DLY_W-1:0]  dly_q;
   logic              arm_q;
   logic [REM_W-1:0]  rem_q;

   assign hx          = GEOM_W'(h_i);
   assign vx          = GEOM_W'(v_i);
   assign pix_req_o   = (hx < h_disp_i) && (vx < v_disp_i);
   assign in_lp_win   = (hx >= lp_start_i) && (hx < lp_start_i + GEOM_W'(LP_WIDTH));
   assign lp_fall_now = (hx == lp_start_i);
   assign last_line   = (vx == v_total_i - GEOM_W'(1));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         drdy_q    <= 1'b0;
         lp_n_q    <= 1'b1;
         fp_n_q    <= 1'b1;
         dly_run_q <= 1'b0;
         dly_q     <= '0;
         arm_q     <= 1'b0;
         rem_q     <= '0;
      end else begin
         drdy_q <= pix_req_o;
         lp_n_q <= ~in_lp_win;

         // Delay line from each line pulse falling edge to a frame pulse event.
         if (dly_run_q) begin
            if (dly_q == '0) begin
               dly_run_q <= 1'b0;
               if (arm_q) begin
                  fp_n_q <= 1'b0;
                  rem_q  <= REM_W'(FP_LINES);
               end else if (!fp_n_q) begin
                  if (rem_q == REM_W'(1)) begin
                     fp_n_q <= 1'b1;
                  end else begin
                     rem_q <= rem_q - REM_W'(1);
                  end
               end
            end else begin
               dly_q <= dly_q - DLY_W'(1);
            end
         end

         if (lp_fall_now) begin
            dly_run_q <= 1'b1;
            dly_q     <= DLY_W'(FP_LEAD - 1);
            arm_q     <= last_line;
         end
      end
   end

   assign drdy_o = drdy_q;
   assign lp_n_o = lp_n_q;
   assign fp_n_o = fp_n_q;

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcdt_pkg::*;
#(
   parameter int HDP_W      = 7,
   parameter int HNDP_W     = 5,
   parameter int HPS_W      = 5,
   parameter int VDP_W      = 10,
   parameter int VNDP_W     = 7,
   parameter int UNIT_LOG2  = 3,
   parameter int HBLANK_OFS = 4,
   parameter int LP_OFS     = 16,
   parameter int LP_WIDTH   = 9,
   parameter int FP_LEAD    = 18,
   parameter int FP_LINES   = 2,
   parameter bit SHADOW_EN  = 1'b1,
   localparam int UNIT      = 1 << UNIT_LOG2,
   localparam int H_MAX     = ((1 << HDP_W) + (1 << HNDP_W) - 1 + HBLANK_OFS) * UNIT,
   localparam int V_MAX     = (1 << VDP_W) + (1 << VNDP_W) - 1,
   localparam int HCNT_W    = $clog2(H_MAX),
   localparam int VCNT_W    = $clog2(V_MAX)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [HDP_W-1:0]  act_w_i,
   input  logic [HNDP_W-1:0] blank_w_i,
   input  logic [HPS_W-1:0]  lp_pos_i,
   input  logic [VDP_W-1:0]  act_h_i,
   input  logic [VNDP_W-1:0] blank_h_i,
   output logic              sclk_o,
   output logic              lp_n_o,
   output logic              fp_n_o,
   output logic              drdy_o,
   output logic              pix_req_o,
   output logic [HCNT_W-1:0] hpos_o,
   output logic [VCNT_W-1:0] vpos_o
);

   // Elaboration-time parameter checks.
   generate
      if (HCNT_W > GEOM_W || VCNT_W > GEOM_W) begin : g_bad_width
         $error("lcd_timing_gen: counter width exceeds geometry width");
      end
      if (LP_OFS + LP_WIDTH >= HBLANK_OFS * UNIT) begin : g_bad_lp
         $error("lcd_timing_gen: line pulse does not fit in the minimum blanking");
      end
      if (FP_LEAD < 1 || FP_LEAD >= (1 + HBLANK_OFS) * UNIT) begin : g_bad_lead
         $error("lcd_timing_gen: frame pulse lead must be shorter than a line");
      end
      if (FP_LINES < 1) begin : g_bad_lines
         $error("lcd_timing_gen: frame pulse must span at least one line");
      end
   endgenerate

   lcdt_geom_t        geom_d;
   lcdt_geom_t        geom_q;
   logic [HCNT_W-1:0] h_cnt;
   logic [VCNT_W-1:0] v_cnt;
   logic              frame_end;

   // Decode the programmed fields into clock and line counts.
   always_comb begin
      geom_d.h_disp   = GEOM_W'((int'(act_w_i) + 1) * UNIT);
      geom_d.h_total  = geom_d.h_disp + GEOM_W'((int'(blank_w_i) + HBLANK_OFS) * UNIT);
      geom_d.lp_start = geom_d.h_disp + GEOM_W'(int'(lp_pos_i) * UNIT + LP_OFS);
      geom_d.v_disp   = GEOM_W'(int'(act_h_i) + 1);
      geom_d.v_total  = geom_d.v_disp + GEOM_W'(blank_h_i);
   end

   lcdt_shadow #(
      .SHADOW_EN (SHADOW_EN)
   ) u_shadow (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .load_i   (frame_end),
      .geom_d_i (geom_d),
      .geom_q_o (geom_q)
   );

   lcdt_raster_cnt #(
      .HCNT_W (HCNT_W),
      .VCNT_W (VCNT_W)
   ) u_cnt (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .h_total_i   (geom_q.h_total),
      .v_total_i   (geom_q.v_total),
      .h_o         (h_cnt),
      .v_o         (v_cnt),
      .frame_end_o (frame_end)
   );

   lcdt_pulse_gen #(
      .HCNT_W   (HCNT_W),
      .VCNT_W   (VCNT_W),
      .LP_WIDTH (LP_WIDTH),
      .FP_LEAD  (FP_LEAD),
      .FP_LINES (FP_LINES)
   ) u_pulse (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .h_i        (h_cnt),
      .v_i        (v_cnt),
      .h_disp_i   (geom_q.h_disp),
      .lp_start_i (geom_q.lp_start),
      .v_disp_i   (geom_q.v_disp),
      .v_total_i  (geom_q.v_total),
      .pix_req_o  (pix_req_o),
      .drdy_o     (drdy_o),
      .lp_n_o     (lp_n_o),
      .fp_n_o     (fp_n_o)
   );

   assign sclk_o = clk_i;
   assign hpos_o = h_cnt;
   assign vpos_o = v_cnt;

endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker #(
   parameter int LP_WIDTH = 9,
   parameter int HCNT_W   = 11,
   parameter int VCNT_W   = 11
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              lp_n_o,
   input logic              fp_n_o,
   input logic              drdy_o,
   input logic              pix_req_o,
   input logic [HCNT_W-1:0] hpos_o,
   input logic [VCNT_W-1:0] vpos_o
);

   logic       past_rst_q = 1'b0;
   logic [7:0] lp_low_cnt = '0;

   always_ff @(posedge clk_i) begin
      past_rst_q <= rst_i;
      if (rst_i || lp_n_o) begin
         lp_low_cnt <= '0;
      end else if (lp_low_cnt != 8'hFF) begin
         lp_low_cnt <= lp_low_cnt + 8'd1;
      end
   end

   AST_RESET_STATE: assert property (@(posedge clk_i) disable iff (rst_i)
      past_rst_q |-> (hpos_o == '0 && vpos_o == '0 && lp_n_o && fp_n_o && !drdy_o)); // R8

   AST_HPOS_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (hpos_o != '0) |-> (hpos_o == $past(hpos_o) + HCNT_W'(1))); // R2

   AST_VPOS_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      (hpos_o != '0) |-> $stable(vpos_o)); // R3

   AST_DRDY_LAG: assert property (@(posedge clk_i) disable iff (rst_i)
      !past_rst_q |-> (drdy_o == $past(pix_req_o))); // R4

   AST_LP_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
      ($rose(lp_n_o) && !past_rst_q) |-> (lp_low_cnt == 8'(LP_WIDTH))); // R6

   AST_LP_NOT_IN_DISPLAY: assert property (@(posedge clk_i) disable iff (rst_i)
      !lp_n_o |-> !drdy_o); // R10

endmodule

bind lcd_timing_gen lcdt_checker #(
   .LP_WIDTH (LP_WIDTH),
   .HCNT_W   (HCNT_W),
   .VCNT_W   (VCNT_W)
) u_lcdt_checker (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .lp_n_o    (lp_n_o),
   .fp_n_o    (fp_n_o),
   .drdy_o    (drdy_o),
   .pix_req_o (pix_req_o),
   .hpos_o    (hpos_o),
   .vpos_o    (vpos_o)
);

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [6:0]  act_w = '0;
   logic [4:0]  blank_w = '0;
   logic [4:0]  lp_pos = '0;
   logic [9:0]  act_h = '0;
   logic [6:0]  blank_h = '0;
   logic        sclk, lp_n, fp_n, drdy, pix_req;
   logic [10:0] hpos, vpos;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   bit started = 1'b0;
   bit change_phase = 1'b0;

   always #5 clk = ~clk;

   lcd_timing_gen dut (
      .clk_i     (clk),
      .rst_i     (rst),
      .act_w_i   (act_w),
      .blank_w_i (blank_w),
      .lp_pos_i  (lp_pos),
      .act_h_i   (act_h),
      .blank_h_i (blank_h),
      .sclk_o    (sclk),
      .lp_n_o    (lp_n),
      .fp_n_o    (fp_n),
      .drdy_o    (drdy),
      .pix_req_o (pix_req),
      .hpos_o    (hpos),
      .vpos_o    (vpos)
   );

   // Behavioural reference: geometry in integers, event countdown for the frame pulse.
   int sh_ht, sh_hd, sh_lp, sh_vt, sh_vd;
   int mh, mv, pend, rem;
   bit e_drdy, e_lp, e_fp, arm, in_rst;

   task automatic load_geom();
      sh_hd = (int'(act_w) + 1) * 8;
      sh_ht = sh_hd + (int'(blank_w) + 4) * 8;
      sh_lp = sh_hd + int'(lp_pos) * 8 + 16;
      sh_vd = int'(act_h) + 1;
      sh_vt = sh_vd + int'(blank_h);
   endtask

   always @(posedge clk) begin
      started = 1'b1;
      in_rst  = rst;
      if (rst) begin
         load_geom();
         mh = 0; mv = 0; pend = 0; rem = 0;
         e_drdy = 0; e_lp = 1; e_fp = 1; arm = 0;
      end else begin
         e_drdy = (mh < sh_hd) && (mv < sh_vd);
         e_lp   = !((mh >= sh_lp) && (mh < sh_lp + 9));
         if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
               if (arm) begin
                  e_fp = 0; rem = 2;
               end else if (!e_fp) begin
                  if (rem == 1) e_fp = 1;
                  else rem = rem - 1;
               end
            end
         end
         if (mh == sh_lp) begin
            pend = 18;
            arm  = (mv == sh_vt - 1);
         end
         if (mh == sh_ht - 1) begin
            mh = 0;
            if (mv == sh_vt - 1) begin
               mv = 0;
               load_geom();
            end else begin
               mv = mv + 1;
            end
         end else begin
            mh = mh + 1;
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (hpos model %0d vpos model %0d) at %0t",
                  req, what, act, exp, mh, mv, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started && !done) begin
         string rq_h, rq_v, rq_d;
         bit    e_req;
         e_req = (mh < sh_hd) && (mv < sh_vd);
         rq_h  = in_rst ? "R8" : (change_phase ? "R9" : "R2");
         rq_v  = in_rst ? "R8" : (change_phase ? "R9" : "R3");
         rq_d  = in_rst ? "R8" : ((mv >= sh_vd) ? "R5" : "R4");
         check(rq_h, "hpos", int'(hpos), mh);
         check(rq_v, "vpos", int'(vpos), mv);
         check(in_rst ? "R8" : "R4", "pix_req", int'(pix_req), int'(e_req));
         check(rq_d, "drdy", int'(drdy), int'(e_drdy));
         check(in_rst ? "R8" : "R6", "lp_n", int'(lp_n), int'(e_lp));
         check(in_rst ? "R8" : "R7", "fp_n", int'(fp_n), int'(e_fp));
         check("R1", "sclk low phase", int'(sclk), 0);
         if (drdy && !lp_n) check("R10", "lp low during drdy", 1, 0);
      end
   end

   always @(posedge clk) begin
      #2;
      if (started && !done) check("R1", "sclk high phase", int'(sclk), 1);
   end

   task automatic cfg(input int aw, input int bw, input int lp, input int ah, input int bh);
      act_w   = 7'(aw);
      blank_w = 5'(bw);
      lp_pos  = 5'(lp);
      act_h   = 10'(ah);
      blank_h = 7'(bh);
   endtask

   task automatic run_frames(input int n);
      repeat (n * sh_ht * sh_vt) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      // Config A: small frame, lp at earliest position.
      cfg(1, 0, 0, 3, 2);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      run_frames(3);
      // Config B: lp at latest legal position, four-line frame (R6, R7).
      cfg(0, 2, 2, 0, 3);
      do_reset();
      run_frames(3);
      // Config C: fields changed mid-frame, must wait for the boundary (R9).
      repeat (sh_ht + 5) @(negedge clk);
      change_phase = 1'b1;
      cfg(2, 1, 1, 4, 0);
      run_frames(1);
      change_phase = 1'b0;
      // Config D: no vertical blanking lines.
      run_frames(3);
      // Reset in the middle of a line (R8), then a wider line.
      repeat (7) @(negedge clk);
      cfg(3, 3, 1, 2, 1);
      do_reset();
      run_frames(2);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule